// File: doc/BRIEF.md
# Register Command List Processor

This block walks a list of packed register-write commands held in a word-wide memory and turns each command into one or more register write transactions. Software gives a start byte address and a list length in bytes, then pulses a start strobe. The block reads each command as a data word followed by a header word. The header names a target register, selects which byte lanes are written, gives a count of extra data words, and chooses whether the index steps forward or stays fixed for those extra words.

Commands always begin on an even word offset. The block fetches every word through a valid/ready read port and presents each write for one cycle on an index/data/mask port. When no further command fits in the list, it pulses a completion interrupt and drops busy.

Top module: `cmdlist_proc`

## Requirements
- R1: On an accepted start, the start address is taken with its low 3 bits cleared and the size with its low 2 bits cleared. The list length in words is the cleared size divided by 4, and word k is read from the cleared address plus 4*k.
- R2: Before each command, an odd word offset is rounded up to the next even offset. A command is decoded only if the rounded offset plus 2 is no larger than the list length. Otherwise the list ends.
- R3: The first word of a command is the data word and the second is the header. The first write places that data word at the register index in header bits [15:0].
- R4: Header bits [19:16] select byte lanes: bit n set makes byte n of the 32-bit wr_mask_o all ones, and clear makes it zero. All writes of the command use the same mask.
- R5: Header bits [27:20] give the number of extra data words. Each extra word is read from the next word offset and produces one further write.
- R6: With header bit 31 set, the index rises by 1 for each extra write. With it clear, every write of the command uses the same index.
- R7: busy_o goes high in the cycle after an accepted start and stays high up to and including the single cycle in which done_irq_o pulses. It is low in the cycle after that.
- R8: A start strobe while busy_o is high is ignored: the running list completes unchanged and no second list runs.
- R9: A read request holds its address until mem_rd_ready_i is high. A stalled read loses no state, so the writes match an unstalled run.
- R10: Out of reset, busy_o, done_irq_o, wr_valid_o and mem_rd_valid_o are low.
- R11: A list shorter than one command completes with no memory reads and no writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start strobe |
| base_addr_i | input | ADDR_W | List start byte address |
| size_i | input | SIZE_W | List length in bytes |
| mem_rd_valid_o | output | 1 | Read request valid |
| mem_rd_addr_o | output | ADDR_W | Read byte address (word aligned) |
| mem_rd_ready_i | input | 1 | Read data present this cycle |
| mem_rd_data_i | input | 32 | Read data word |
| wr_valid_o | output | 1 | Register write strobe |
| wr_index_o | output | 16 | Register index |
| wr_data_o | output | 32 | Write data |
| wr_mask_o | output | 32 | Per-bit write mask expanded from the byte lanes |
| busy_o | output | 1 | List in progress |
| done_irq_o | output | 1 | Completion pulse |

## Verification
The assertions check the handshake and framing rules on every cycle:
- a stalled read keeps its address;
- read addresses stay word aligned;
- the completion pulse lasts one cycle and falls within busy;
- busy falls only right after that pulse;
- writes occur only while busy;
- a start during a run cannot drop busy.

The decode results can only be shown by the bench's directed lists, which compare every captured write against values worked out by hand. These results are the index stepping, the byte-lane expansion, the even-offset realignment, the length cutoff, and the cleared low address and size bits.

// File: rtl/cmdlist_pkg.sv
package cmdlist_pkg;
  localparam int IDX_W  = 16;
  localparam int SEL_W  = 4;
  localparam int CNT_W  = 8;
  localparam int SEL_LO = 16;
  localparam int CNT_LO = 20;
  localparam int INC_B  = 31;

  typedef enum logic [2:0] {
    S_IDLE, S_CMD, S_PARAM, S_HDR, S_WRITE, S_EXTRA, S_DONE
  } state_e;

  typedef struct packed {
    logic [IDX_W-1:0] idx;
    logic [31:0]      mask;
    logic [CNT_W-1:0] cnt;
    logic             inc;
  } hdr_t;
endpackage

// File: rtl/cmdlist_hdr_dec.sv
module cmdlist_hdr_dec
  import cmdlist_pkg::*;
(
  input  logic [31:0] hdr_i,
  output hdr_t        dec_o
);
  logic [SEL_W-1:0] sel;
  assign sel = hdr_i[SEL_LO +: SEL_W];

  for (genvar g = 0; g < SEL_W; g++) begin : g_lane
    assign dec_o.mask[g*8 +: 8] = {8{sel[g]}};
  end

  assign dec_o.idx = hdr_i[IDX_W-1:0];
  assign dec_o.cnt = hdr_i[CNT_LO +: CNT_W];
  assign dec_o.inc = hdr_i[INC_B];
endmodule

// File: rtl/cmdlist_cursor.sv
module cmdlist_cursor #(
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              align_i,
  input  logic              adv_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [SIZE_W-1:0] size_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              fits_o
);
  localparam int LEN_W = SIZE_W - 2;
  localparam int OFF_W = LEN_W + 1;
  localparam int EXT_W = LEN_W + 2;

  logic [ADDR_W-4:0] base_q;
  logic [LEN_W-1:0]  len_q;
  logic [OFF_W-1:0]  off_q;
  logic [EXT_W-1:0]  off_even;

  assign off_even = {1'b0, off_q} + EXT_W'(off_q[0]);
  assign fits_o   = (off_even + EXT_W'(2)) <= {2'b00, len_q};
  assign addr_o   = {base_q, 3'b000} + ADDR_W'({off_q, 2'b00});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      len_q  <= '0;
      off_q  <= '0;
    end else if (load_i) begin
      base_q <= base_i[ADDR_W-1:3];
      len_q  <= size_i[SIZE_W-1:2];
      off_q  <= '0;
    end else if (align_i) begin
      off_q  <= off_even[OFF_W-1:0];
    end else if (adv_i) begin
      off_q  <= off_q + OFF_W'(1);
    end
  end
endmodule

// File: rtl/cmdlist_proc.sv
module cmdlist_proc
  import cmdlist_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] base_addr_i,
  input  logic [SIZE_W-1:0] size_i,
  output logic              mem_rd_valid_o,
  output logic [ADDR_W-1:0] mem_rd_addr_o,
  input  logic              mem_rd_ready_i,
  input  logic [31:0]       mem_rd_data_i,
  output logic              wr_valid_o,
  output logic [15:0]       wr_index_o,
  output logic [31:0]       wr_data_o,
  output logic [31:0]       wr_mask_o,
  output logic              busy_o,
  output logic              done_irq_o
);
  state_e           state_q;
  logic [31:0]      param_q;
  logic [IDX_W-1:0] idx_q;
  logic [31:0]      mask_q;
  logic [CNT_W-1:0] cnt_q;
  logic             inc_q;
  hdr_t             dec;
  logic             fits, rd_fire, load;

  assign mem_rd_valid_o = (state_q == S_PARAM) || (state_q == S_HDR) || (state_q == S_EXTRA);
  assign rd_fire        = mem_rd_valid_o && mem_rd_ready_i;
  assign load           = (state_q == S_IDLE) && start_i;

  cmdlist_hdr_dec u_dec (.hdr_i(mem_rd_data_i), .dec_o(dec));

  cmdlist_cursor #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_cur (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .align_i((state_q == S_CMD) && fits),
    .adv_i  (rd_fire),
    .base_i (base_addr_i),
    .size_i (size_i),
    .addr_o (mem_rd_addr_o),
    .fits_o (fits)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      param_q <= '0;
      idx_q   <= '0;
      mask_q  <= '0;
      cnt_q   <= '0;
      inc_q   <= 1'b0;
    end else begin
      unique case (state_q)
        S_IDLE:  if (start_i) state_q <= S_CMD;
        S_CMD:   state_q <= fits ? S_PARAM : S_DONE;
        S_PARAM: if (rd_fire) begin
          param_q <= mem_rd_data_i;
          state_q <= S_HDR;
        end
        S_HDR: if (rd_fire) begin
          idx_q   <= dec.idx;
          mask_q  <= dec.mask;
          cnt_q   <= dec.cnt;
          inc_q   <= dec.inc;
          state_q <= S_WRITE;
        end
        S_WRITE: begin
          if (cnt_q == '0) begin
            state_q <= S_CMD;
          end else begin
            cnt_q   <= cnt_q - CNT_W'(1);
            idx_q   <= idx_q + IDX_W'(inc_q);
            state_q <= S_EXTRA;
          end
        end
        S_EXTRA: if (rd_fire) begin
          param_q <= mem_rd_data_i;
          state_q <= S_WRITE;
        end
        S_DONE:  state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign wr_valid_o = (state_q == S_WRITE);
  assign wr_index_o = idx_q;
  assign wr_data_o  = param_q;
  assign wr_mask_o  = mask_q;
  assign busy_o     = (state_q != S_IDLE);
  assign done_irq_o = (state_q == S_DONE);
endmodule

// File: rtl/cmdlist_chk.sv
module cmdlist_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              mem_rd_valid_o,
  input logic [ADDR_W-1:0] mem_rd_addr_o,
  input logic              mem_rd_ready_i,
  input logic              wr_valid_o,
  input logic              busy_o,
  input logic              done_irq_o
);
  assert_stall_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_valid_o && !mem_rd_ready_i |=> mem_rd_valid_o && $stable(mem_rd_addr_o));

  assert_word_addr_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_valid_o |-> mem_rd_addr_o[1:0] == 2'b00);

  assert_done_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_irq_o |=> !done_irq_o);

  assert_done_in_busy_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_irq_o |-> busy_o);

  assert_busy_fall_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> $past(done_irq_o));

  assert_write_busy_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o |-> busy_o);

  assert_start_ignored_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && busy_o && !done_irq_o |=> busy_o);
endmodule

bind cmdlist_proc cmdlist_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .start_i        (start_i),
  .mem_rd_valid_o (mem_rd_valid_o),
  .mem_rd_addr_o  (mem_rd_addr_o),
  .mem_rd_ready_i (mem_rd_ready_i),
  .wr_valid_o     (wr_valid_o),
  .busy_o         (busy_o),
  .done_irq_o     (done_irq_o)
);

// File: tb/sim_cmdlist_proc.sv
`timescale 1ns/1ps
module sim_cmdlist_proc;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] base = '0;
  logic [19:0] size = '0;
  logic        rd_valid, rd_ready;
  logic [31:0] rd_addr, rd_data;
  logic        wr_valid, busy, done_irq;
  logic [15:0] wr_index;
  logic [31:0] wr_data, wr_mask;

  always #2 clk = ~clk;

  logic [31:0] mem_w [64];
  assign rd_data = mem_w[rd_addr[7:2]];

  logic stall_en = 1'b0;
  logic rdy_q = 1'b1;
  always @(negedge clk) rdy_q <= stall_en ? ~rdy_q : 1'b1;
  assign rd_ready = rdy_q;

  cmdlist_proc u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .base_addr_i(base), .size_i(size),
    .mem_rd_valid_o(rd_valid), .mem_rd_addr_o(rd_addr), .mem_rd_ready_i(rd_ready),
    .mem_rd_data_i(rd_data), .wr_valid_o(wr_valid), .wr_index_o(wr_index),
    .wr_data_o(wr_data), .wr_mask_o(wr_mask), .busy_o(busy), .done_irq_o(done_irq)
  );

  int n_chk = 0, n_fail = 0;
  int cap_n = 0, done_cnt = 0, rd_cnt = 0;
  logic [15:0] cap_idx  [16];
  logic [31:0] cap_data [16];
  logic [31:0] cap_mask [16];

  always @(negedge clk) begin
    if (wr_valid && cap_n < 16) begin
      cap_idx[cap_n]  = wr_index;
      cap_data[cap_n] = wr_data;
      cap_mask[cap_n] = wr_mask;
      cap_n = cap_n + 1;
    end
    if (done_irq) done_cnt = done_cnt + 1;
    if (rd_valid && rd_ready) rd_cnt = rd_cnt + 1;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic expect_wr(input int k, input logic [15:0] idx, input logic [31:0] dat,
                           input logic [31:0] msk, input string req);
    chk(cap_idx[k] == idx, req, $sformatf("write %0d index", k), 32'(cap_idx[k]), 32'(idx));
    chk(cap_data[k] == dat, req, $sformatf("write %0d data", k), cap_data[k], dat);
    chk(cap_mask[k] == msk, req, $sformatf("write %0d mask", k), cap_mask[k], msk);
  endtask

  function automatic logic [31:0] hdr(input logic [15:0] idx, input logic [3:0] sel,
                                      input logic [7:0] cnt, input logic inc);
    return {inc, 3'b000, cnt, sel, idx};
  endfunction

  task automatic clear_mem();
    for (int i = 0; i < 64; i++) mem_w[i] = 32'hBAD0_0000 | 32'(i);
  endtask

  task automatic run_list(input logic [31:0] b, input logic [19:0] s, input bit poke);
    int w = 0;
    cap_n = 0; done_cnt = 0; rd_cnt = 0;
    @(negedge clk);
    base = b; size = s; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R7", "busy after start", 32'(busy), 32'd1);
    while (!done_irq && w < 500) begin
      if (poke && w == 3) begin
        base = 32'h0; size = 20'd64; start = 1'b1;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      w++;
    end
    start = 1'b0;
    chk(w < 500, "R7", "completion reached", 32'(w), 32'd0);
    chk(busy == 1'b1, "R7", "busy during done pulse", 32'(busy), 32'd1);
    @(negedge clk);
    chk(busy == 1'b0, "R7", "busy low after done", 32'(busy), 32'd0);
    repeat (4) @(negedge clk);
    chk(done_cnt == 1, "R7", "done pulse count", 32'(done_cnt), 32'd1);
  endtask

  task automatic t_reset();
    chk(busy == 1'b0, "R10", "busy in reset", 32'(busy), 32'd0);
    chk(done_irq == 1'b0, "R10", "done in reset", 32'(done_irq), 32'd0);
    chk(wr_valid == 1'b0, "R10", "write in reset", 32'(wr_valid), 32'd0);
    chk(rd_valid == 1'b0, "R10", "read in reset", 32'(rd_valid), 32'd0);
  endtask

  task automatic t_basic();
    clear_mem();
    mem_w[0] = 32'h1122_3344;
    mem_w[1] = hdr(16'h0010, 4'hF, 8'd0, 1'b0);
    run_list(32'h0, 20'd8, 1'b0);
    chk(cap_n == 1, "R3", "write count", 32'(cap_n), 32'd1);
    expect_wr(0, 16'h0010, 32'h1122_3344, 32'hFFFF_FFFF, "R3");
  endtask

  task automatic t_multi_inc(input string req);
    clear_mem();
    mem_w[0] = 32'hA000_0001;
    mem_w[1] = hdr(16'h0020, 4'b0101, 8'd2, 1'b1);
    mem_w[2] = 32'hA000_0002;
    mem_w[3] = 32'hA000_0003;
    run_list(32'h0, 20'd16, 1'b0);
    chk(cap_n == 3, req, "write count", 32'(cap_n), 32'd3);
    expect_wr(0, 16'h0020, 32'hA000_0001, 32'h00FF_00FF, req);
    expect_wr(1, 16'h0021, 32'hA000_0002, 32'h00FF_00FF, req);
    expect_wr(2, 16'h0022, 32'hA000_0003, 32'h00FF_00FF, req);
  endtask

  task automatic t_align();
    clear_mem();
    mem_w[0] = 32'hC000_0000;
    mem_w[1] = hdr(16'h0030, 4'hF, 8'd1, 1'b0);
    mem_w[2] = 32'hC000_0001;
    mem_w[3] = 32'hDEAD_BEEF;
    mem_w[4] = 32'hC000_0002;
    mem_w[5] = hdr(16'h0040, 4'b1000, 8'd0, 1'b0);
    run_list(32'h0, 20'd24, 1'b0);
    chk(cap_n == 3, "R2", "write count after realign", 32'(cap_n), 32'd3);
    expect_wr(0, 16'h0030, 32'hC000_0000, 32'hFFFF_FFFF, "R6");
    expect_wr(1, 16'h0030, 32'hC000_0001, 32'hFFFF_FFFF, "R6");
    expect_wr(2, 16'h0040, 32'hC000_0002, 32'hFF00_0000, "R2");
  endtask

  task automatic t_unaligned_base();
    clear_mem();
    mem_w[16] = 32'h5555_AAAA;
    mem_w[17] = hdr(16'h0007, 4'b0011, 8'd0, 1'b0);
    run_list(32'h0000_0045, 20'h0000B, 1'b0);
    chk(cap_n == 1, "R1", "write count", 32'(cap_n), 32'd1);
    chk(rd_cnt == 2, "R1", "read count", 32'(rd_cnt), 32'd2);
    expect_wr(0, 16'h0007, 32'h5555_AAAA, 32'h0000_FFFF, "R1");
  endtask

  task automatic t_trailing();
    clear_mem();
    mem_w[0] = 32'h7777_0000;
    mem_w[1] = hdr(16'h0050, 4'b0010, 8'd0, 1'b0);
    mem_w[2] = 32'h9999_9999;
    run_list(32'h0, 20'd12, 1'b0);
    chk(cap_n == 1, "R2", "trailing word ignored", 32'(cap_n), 32'd1);
    expect_wr(0, 16'h0050, 32'h7777_0000, 32'h0000_FF00, "R4");
  endtask

  task automatic t_empty();
    clear_mem();
    run_list(32'h0, 20'd4, 1'b0);
    chk(cap_n == 0, "R11", "no writes", 32'(cap_n), 32'd0);
    chk(rd_cnt == 0, "R11", "no reads", 32'(rd_cnt), 32'd0);
  endtask

  task automatic t_busy_start();
    clear_mem();
    mem_w[0] = 32'hE000_0001;
    mem_w[1] = hdr(16'h0060, 4'b1111, 8'd1, 1'b1);
    mem_w[2] = 32'hE000_0002;
    stall_en = 1'b1;
    run_list(32'h0, 20'd12, 1'b1);
    stall_en = 1'b0;
    chk(cap_n == 2, "R8", "writes with start while busy", 32'(cap_n), 32'd2);
    expect_wr(0, 16'h0060, 32'hE000_0001, 32'hFFFF_FFFF, "R8");
    expect_wr(1, 16'h0061, 32'hE000_0002, 32'hFFFF_FFFF, "R8");
    chk(busy == 1'b0, "R8", "no second run", 32'(busy), 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_basic();
    t_multi_inc("R5");
    t_align();
    t_unaligned_base();
    t_trailing();
    t_empty();
    stall_en = 1'b1;
    t_multi_inc("R9");
    stall_en = 1'b0;
    t_busy_start();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule